// File: doc/BRIEF.md
# Strobed Serial Command Receiver with Display Memory

This block is the host-facing front end of a display controller. A host drives three wires: an active-low framing strobe, a shift clock and a data line. A fourth line is an open-drain return. All three inputs are brought into the system clock domain through synchroniser stages, and their edges are found there. Bytes arrive least significant bit first and are sampled on rising shift-clock edges. Inside each strobe-low window, the first complete byte is a command. The bytes that follow are data, and what happens to them depends on that command.

An address-set command selects a byte address in a display memory of 11 digits of 16 segment bits. Each data byte after it is stored at the current address, and the address then advances and wraps after the last byte. A read command captures a key-data word from a parallel source. That word is then returned bit by bit on the open-drain line, changing on falling shift-clock edges. A display scanner reads whole digits through a separate combinational port.

Top module: `vfd_serial_ctrl`

## Requirements
- R1: After reset, every digit read through the scan port is 0 and the open-drain output is released (`sdo_pull_low_o` = 0).
- R2: A command byte whose bits 7:6 are 11 sets the byte address to its bits 4:0. Each complete data byte that follows, taken LSB first on rising shift-clock edges, is stored at that address. An even address fills scan bits 7:0 of digit address/2, and an odd address fills bits 15:8.
- R3: After each stored byte the address advances by one, and after address 0x15 it wraps to 0x00.
- R4: An address-set command carrying an address above 0x15 starts at address 0x00.
- R5: Any strobe edge, rising or falling, discards a partially received byte. The first complete byte after the strobe falls is always taken as a command.
- R6: Shift-clock activity while the strobe is high has no effect on the memory or the output line.
- R7: A command byte with bits 7:6 = 01 and bit 1 = 1 captures `key_data_i` when the command completes. On each later falling shift-clock edge the next captured bit, starting at bit 0, is presented. The output pulls low for a 0 and releases for a 1. Once all captured bits are out, the line stays released, and a strobe rise releases it.
- R8: After any other command (for example 0x40 or 0x00), data bytes in the same strobe window leave the memory unchanged.
- R9: When a strobe edge and the eighth rising shift-clock edge of a data byte reach the block together, the strobe edge wins and the byte is not stored.
- R10: A scan digit index of 11 or more reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strobe_i | input | 1 | Framing strobe, active low, asynchronous |
| sclk_i | input | 1 | Serial shift clock, idles high, asynchronous |
| sdata_i | input | 1 | Serial data in, LSB first |
| sdo_pull_low_o | output | 1 | Open-drain return: 1 drives the line low, 0 releases it |
| scan_digit_i | input | 4 | Digit index for the scanner read port |
| scan_data_o | output | 16 | Segment bits of the selected digit |
| key_data_i | input | 24 | Parallel key-data word captured by a read command |

## Verification
Two of the block's functions can meet in one system cycle. These are the reinitialisation of the framing on a strobe edge and the completion of a byte on the eighth rising shift-clock edge. Both inputs pass through identical synchroniser chains. The bench therefore changes the strobe and the shift clock at the same instant, which makes both edges visible to the framing logic in the same cycle. The outcome is judged at the scan port: the digit that the unfinished byte would have overwritten must keep its previous value, while ordinary eighth-bit completions elsewhere in the bench do store their bytes.

// File: rtl/vfd_serial_pkg.sv
package vfd_serial_pkg;

    localparam int BYTE_W   = 8;
    localparam int CNT_W    = 3;
    localparam int SEG_BITS = 2 * BYTE_W;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'd0,
        MODE_WRITE = 2'd1,
        MODE_READ  = 2'd2
    } rx_mode_e;

    typedef enum logic [1:0] {
        CMD_OTHER = 2'd0,
        CMD_ADDR  = 2'd1,
        CMD_READ  = 2'd2
    } cmd_kind_e;

    // Class of a command byte: bits 7:6 = 11 sets the address,
    // bits 7:6 = 01 with bit 1 set starts a key-data read.
    function automatic cmd_kind_e classify_cmd(input logic [7:6] top2, input logic rd_bit);
        if (top2 == 2'b11)
            return CMD_ADDR;
        else if (top2 == 2'b01 && rd_bit)
            return CMD_READ;
        else
            return CMD_OTHER;
    endfunction

endpackage

// File: rtl/vfd_sync_edge.sv
module vfd_sync_edge #(
    parameter int           W         = 3,
    parameter int           STAGES    = 2,
    parameter logic [W-1:0] RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);

    // STAGES synchroniser flops plus one history flop for edge detection
    logic [STAGES:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = async_i;
        for (int s = 1; s <= STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= {(STAGES+1){RESET_VAL}};
        end else begin
            pipe_q <= pipe_d;
        end
    end

    genvar b;
    generate
        for (b = 0; b < W; b++) begin : g_bit
            assign level_o[b] = pipe_q[STAGES-1][b];
            assign rise_o[b]  = pipe_q[STAGES-1][b] & ~pipe_q[STAGES][b];
            assign fall_o[b]  = ~pipe_q[STAGES-1][b] & pipe_q[STAGES][b];
        end
    endgenerate

endmodule

// File: rtl/vfd_frame_rx.sv
module vfd_frame_rx
    import vfd_serial_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int LAST_ADDR = 21,
    parameter int KEY_BITS  = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                strobe_lvl_i,
    input  logic                strobe_edge_i,
    input  logic                sclk_rise_i,
    input  logic                sclk_fall_i,
    input  logic                sdata_i,
    input  logic [KEY_BITS-1:0] key_data_i,
    output logic                wr_en_o,
    output logic [ADDR_W-1:0]   wr_addr_o,
    output logic [BYTE_W-1:0]   wr_data_o,
    output logic                sdo_pull_low_o,
    output logic [CNT_W-1:0]    bit_cnt_o
);

    localparam logic [ADDR_W-1:0] LAST_A   = ADDR_W'(LAST_ADDR);
    localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0]    bit_cnt;
        logic [BYTE_W-1:0]   shreg;
        logic                first;
        rx_mode_e            mode;
        logic [ADDR_W-1:0]   addr;
        logic [KEY_BITS-1:0] tx_sh;
        logic                tx_bit;
        logic                wr_en;
        logic [ADDR_W-1:0]   wr_addr;
        logic [BYTE_W-1:0]   wr_data;
    } rx_state_t;

    rx_state_t st_d, st_q;
    logic [BYTE_W-1:0] byte_next;
    logic [ADDR_W-1:0] set_addr;
    cmd_kind_e         kind;

    assign byte_next = {sdata_i, st_q.shreg[BYTE_W-1:1]};
    assign set_addr  = byte_next[ADDR_W-1:0];
    assign kind      = classify_cmd(byte_next[7:6], byte_next[1]);

    always_comb begin
        st_d       = st_q;
        st_d.wr_en = 1'b0;
        if (strobe_edge_i) begin
            // any strobe edge reinitialises framing; wins over a clock edge
            st_d.bit_cnt = '0;
            st_d.first   = 1'b1;
            st_d.mode    = MODE_IDLE;
            st_d.tx_bit  = 1'b1;
        end else if (!strobe_lvl_i) begin
            if (sclk_rise_i) begin
                st_d.shreg = byte_next;
                if (st_q.bit_cnt == LAST_BIT) begin
                    st_d.bit_cnt = '0;
                    if (st_q.first) begin
                        st_d.first = 1'b0;
                        unique case (kind)
                            CMD_ADDR: begin
                                st_d.mode = MODE_WRITE;
                                st_d.addr = (set_addr > LAST_A) ? '0 : set_addr;
                            end
                            CMD_READ: begin
                                st_d.mode  = MODE_READ;
                                st_d.tx_sh = key_data_i;
                            end
                            default: st_d.mode = MODE_IDLE;
                        endcase
                    end else if (st_q.mode == MODE_WRITE) begin
                        st_d.wr_en   = 1'b1;
                        st_d.wr_addr = st_q.addr;
                        st_d.wr_data = byte_next;
                        st_d.addr    = (st_q.addr == LAST_A) ? '0 : st_q.addr + 1'b1;
                    end
                end else begin
                    st_d.bit_cnt = st_q.bit_cnt + 1'b1;
                end
            end
            if (sclk_fall_i && st_q.mode == MODE_READ) begin
                st_d.tx_bit = st_q.tx_sh[0];
                st_d.tx_sh  = {1'b1, st_q.tx_sh[KEY_BITS-1:1]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.first   <= 1'b1;
            st_q.mode    <= MODE_IDLE;
            st_q.tx_sh   <= '1;
            st_q.tx_bit  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en_o        = st_q.wr_en;
    assign wr_addr_o      = st_q.wr_addr;
    assign wr_data_o      = st_q.wr_data;
    assign sdo_pull_low_o = ~st_q.tx_bit;
    assign bit_cnt_o      = st_q.bit_cnt;

endmodule

// File: rtl/vfd_disp_ram.sv
module vfd_disp_ram
    import vfd_serial_pkg::*;
#(
    parameter int NUM_DIGITS = 11,
    parameter int DIG_W      = 4,
    parameter int ADDR_W     = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   wr_addr_i,
    input  logic [BYTE_W-1:0]   wr_data_i,
    input  logic [DIG_W-1:0]    scan_digit_i,
    output logic [SEG_BITS-1:0] scan_data_o
);

    logic [SEG_BITS-1:0] mem_d [NUM_DIGITS];
    logic [SEG_BITS-1:0] mem_q [NUM_DIGITS];
    logic [DIG_W-1:0]    wr_digit;
    logic                wr_upper;

    assign wr_digit = wr_addr_i[ADDR_W-1:1];
    assign wr_upper = wr_addr_i[0];

    genvar g;
    generate
        for (g = 0; g < NUM_DIGITS; g++) begin : g_digit
            always_comb begin
                mem_d[g] = mem_q[g];
                if (wr_en_i && wr_digit == DIG_W'(g)) begin
                    if (wr_upper)
                        mem_d[g][SEG_BITS-1:BYTE_W] = wr_data_i;
                    else
                        mem_d[g][BYTE_W-1:0] = wr_data_i;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    mem_q[g] <= '0;
                else
                    mem_q[g] <= mem_d[g];
            end
        end
    endgenerate

    always_comb begin
        scan_data_o = '0;
        for (int i = 0; i < NUM_DIGITS; i++) begin
            if (scan_digit_i == DIG_W'(i))
                scan_data_o = mem_q[i];
        end
    end

endmodule

// File: rtl/vfd_serial_ctrl.sv
module vfd_serial_ctrl
    import vfd_serial_pkg::*;
#(
    parameter int NUM_DIGITS  = 11,
    parameter int KEY_BYTES   = 3,
    parameter int SYNC_STAGES = 2,
    localparam int DIG_W      = $clog2(NUM_DIGITS),
    localparam int KEY_BITS   = KEY_BYTES * BYTE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                strobe_i,
    input  logic                sclk_i,
    input  logic                sdata_i,
    output logic                sdo_pull_low_o,
    input  logic [DIG_W-1:0]    scan_digit_i,
    output logic [SEG_BITS-1:0] scan_data_o,
    input  logic [KEY_BITS-1:0] key_data_i
);

    localparam int ADDR_W    = DIG_W + 1;
    localparam int LAST_ADDR = 2 * NUM_DIGITS - 1;

    // bit 0 strobe, bit 1 shift clock, bit 2 data; both clocks idle high
    logic [2:0]          pin_lvl, pin_rise, pin_fall;
    logic                strobe_lvl, strobe_edge;
    logic                wr_en;
    logic [ADDR_W-1:0]   wr_addr;
    logic [BYTE_W-1:0]   wr_data;
    logic [CNT_W-1:0]    bit_cnt;

    vfd_sync_edge #(
        .W         (3),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (3'b011)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sdata_i, sclk_i, strobe_i}),
        .level_o (pin_lvl),
        .rise_o  (pin_rise),
        .fall_o  (pin_fall)
    );

    assign strobe_lvl  = pin_lvl[0];
    assign strobe_edge = pin_rise[0] | pin_fall[0];

    vfd_frame_rx #(
        .ADDR_W    (ADDR_W),
        .LAST_ADDR (LAST_ADDR),
        .KEY_BITS  (KEY_BITS)
    ) u_rx (
        .clk            (clk),
        .rst_n          (rst_n),
        .strobe_lvl_i   (strobe_lvl),
        .strobe_edge_i  (strobe_edge),
        .sclk_rise_i    (pin_rise[1]),
        .sclk_fall_i    (pin_fall[1]),
        .sdata_i        (pin_lvl[2]),
        .key_data_i     (key_data_i),
        .wr_en_o        (wr_en),
        .wr_addr_o      (wr_addr),
        .wr_data_o      (wr_data),
        .sdo_pull_low_o (sdo_pull_low_o),
        .bit_cnt_o      (bit_cnt)
    );

    vfd_disp_ram #(
        .NUM_DIGITS (NUM_DIGITS),
        .DIG_W      (DIG_W),
        .ADDR_W     (ADDR_W)
    ) u_ram (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (wr_en),
        .wr_addr_i    (wr_addr),
        .wr_data_i    (wr_data),
        .scan_digit_i (scan_digit_i),
        .scan_data_o  (scan_data_o)
    );

endmodule

// File: rtl/vfd_serial_ctrl_chk.sv
module vfd_serial_ctrl_chk #(
    parameter int DIG_W     = 4,
    parameter int ADDR_W    = 5,
    parameter int LAST_ADDR = 21
) (
    input logic              clk,
    input logic              rst_n,
    input logic              strobe_lvl,
    input logic              strobe_edge,
    input logic [2:0]        bit_cnt,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DIG_W-1:0]  scan_digit_i,
    input logic [15:0]       scan_data_o,
    input logic              sdo_pull_low_o
);

    // R2: memory content changes only one cycle after a write strobe
    p_ram_needs_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (!$stable(scan_digit_i) || $stable(scan_data_o)));

    // R3, R4: a write never targets an address past the last byte
    p_addr_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr <= ADDR_W'(LAST_ADDR)));

    // R5: a strobe edge leaves the bit counter at zero
    p_partial_dropped_r5: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_edge |=> (bit_cnt == 3'd0));

    // R6: framing stays frozen while the strobe is high
    p_clk_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_lvl && !strobe_edge) |=> $stable(bit_cnt));

    // R7: the return line is released after any strobe edge
    p_release_on_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_edge |=> !sdo_pull_low_o);

    // R9: no write is issued in the cycle after a strobe edge
    p_strobe_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_edge |=> !wr_en);

endmodule

bind vfd_serial_ctrl vfd_serial_ctrl_chk #(
    .DIG_W     (DIG_W),
    .ADDR_W    (ADDR_W),
    .LAST_ADDR (LAST_ADDR)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .strobe_lvl     (strobe_lvl),
    .strobe_edge    (strobe_edge),
    .bit_cnt        (bit_cnt),
    .wr_en          (wr_en),
    .wr_addr        (wr_addr),
    .scan_digit_i   (scan_digit_i),
    .scan_data_o    (scan_data_o),
    .sdo_pull_low_o (sdo_pull_low_o)
);

// File: tb/vfd_serial_ctrl_bench.sv
module vfd_serial_ctrl_bench;

    localparam int HALF  = 6;
    localparam int NDIG  = 11;
    localparam int NVEC  = 6;

    // {start address, byte 0, byte 1, digit to check, expected digit}
    localparam logic [40:0] VECS [NVEC] = '{
        {5'h00, 8'h3C, 8'hA5, 4'd0,  16'hA53C},   // R2 even then odd
        {5'h06, 8'h01, 8'h80, 4'd3,  16'h8001},   // R2
        {5'h15, 8'h5A, 8'h99, 4'd10, 16'h5A00},   // R2 odd only, R3 wrap follows
        {5'h01, 8'hBB, 8'h44, 4'd0,  16'hBB99},   // R3 wrapped byte landed at 0x00
        {5'h1F, 8'h77, 8'h66, 4'd0,  16'h6677},   // R4 out-of-range start
        {5'h08, 8'hC3, 8'h3C, 4'd4,  16'h3CC3}    // R3 increment into odd half
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        strobe, sclk, sdata;
    logic        sdo_pull_low;
    logic [3:0]  scan_digit;
    logic [15:0] scan_data;
    logic [23:0] key_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [15:0] snap [NDIG];

    always #5 clk = ~clk;

    vfd_serial_ctrl u_vfd_serial_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .strobe_i       (strobe),
        .sclk_i         (sclk),
        .sdata_i        (sdata),
        .sdo_pull_low_o (sdo_pull_low),
        .scan_digit_i   (scan_digit),
        .scan_data_o    (scan_data),
        .key_data_i     (key_data)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        sclk = 1'b0; sdata = b;
        tick(HALF);
        sclk = 1'b1;
        tick(HALF);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
    endtask

    task automatic frame_begin();
        strobe = 1'b0;
        tick(HALF);
    endtask

    task automatic frame_end();
        tick(HALF);
        strobe = 1'b1;
        tick(4 * HALF);
    endtask

    task automatic peek(input int d, output logic [15:0] v);
        scan_digit = 4'(d);
        tick(1);
        v = scan_data;
    endtask

    task automatic take_snap();
        for (int d = 0; d < NDIG; d++) peek(d, snap[d]);
    endtask

    task automatic compare_snap(input string req);
        logic [15:0] v;
        for (int d = 0; d < NDIG; d++) begin
            peek(d, v);
            check(v == snap[d], req, {12'h0, 4'(d), v}, {12'h0, 4'(d), snap[d]});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [23:0] key_a;
        rst_n = 1'b0; strobe = 1'b1; sclk = 1'b1; sdata = 1'b0;
        scan_digit = '0; key_data = '0;
        tick(5);
        rst_n = 1'b1;
        tick(4);

        // R1: reset state
        for (int d = 0; d < NDIG; d++) begin
            peek(d, v);
            check(v == 16'h0, "R1", {16'h0, v}, 32'h0);
        end
        check(sdo_pull_low == 1'b0, "R1", {31'h0, sdo_pull_low}, 32'h0);

        // R2/R3/R4: table of address-set frames
        for (int k = 0; k < NVEC; k++) begin
            frame_begin();
            send_byte({3'b110, VECS[k][40:36]});
            send_byte(VECS[k][35:28]);
            send_byte(VECS[k][27:20]);
            frame_end();
            peek(int'(VECS[k][19:16]), v);
            check(v == VECS[k][15:0], "R2/R3/R4 table", {16'h0, v}, {16'h0, VECS[k][15:0]});
        end
        peek(1, v);
        check(v == 16'h0044, "R3 increment across digit", {16'h0, v}, 32'h0044);

        // R10: indices past the last digit read as zero
        peek(11, v);
        check(v == 16'h0, "R10", {16'h0, v}, 32'h0);
        peek(15, v);
        check(v == 16'h0, "R10", {16'h0, v}, 32'h0);

        // R8: other commands leave memory untouched
        take_snap();
        frame_begin();
        send_byte(8'h40); send_byte(8'hFF); send_byte(8'hFF);
        frame_end();
        frame_begin();
        send_byte(8'h00); send_byte(8'hEE);
        frame_end();
        compare_snap("R8");

        // R5 and R6: partial byte cut by strobe, clocks while strobe high
        take_snap();
        frame_begin();
        send_byte(8'hC4);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        frame_end();
        for (int i = 0; i < 5; i++) send_bit(1'b1);   // R6: strobe high
        check(sdo_pull_low == 1'b0, "R6", {31'h0, sdo_pull_low}, 32'h0);
        compare_snap("R5 partial byte dropped");
        frame_begin();
        send_byte(8'hC6); send_byte(8'h5E);
        frame_end();
        peek(3, v);
        check(v == 16'h805E, "R5 first byte is command", {16'h0, v}, 32'h805E);
        peek(2, v);
        check(v == snap[2], "R5", {16'h0, v}, {16'h0, snap[2]});

        // R7: key-data read-back
        key_a = 24'h5A0F81;
        key_data = key_a;
        frame_begin();
        send_byte(8'h42);
        key_data = 24'h000000;   // capture happened at command completion
        for (int i = 0; i < 24; i++) begin
            sclk = 1'b0; sdata = 1'b1;
            tick(HALF);
            check(sdo_pull_low == ~key_a[i], "R7 read bit",
                  {31'h0, sdo_pull_low}, {31'h0, ~key_a[i]});
            sclk = 1'b1;
            tick(HALF);
        end
        sclk = 1'b0;
        tick(HALF);
        check(sdo_pull_low == 1'b0, "R7 released after last bit", {31'h0, sdo_pull_low}, 32'h0);
        sclk = 1'b1;
        tick(HALF);
        // R7: strobe rise releases a line held low
        key_data = 24'h000000;
        frame_end();
        frame_begin();
        send_byte(8'h42);
        sclk = 1'b0;
        tick(HALF);
        check(sdo_pull_low == 1'b1, "R7 zero bit pulls low", {31'h0, sdo_pull_low}, 32'h1);
        sclk = 1'b1;
        tick(HALF);
        frame_end();
        check(sdo_pull_low == 1'b0, "R7 strobe rise releases", {31'h0, sdo_pull_low}, 32'h0);

        // R9: strobe rise coincident with the eighth rising clock edge
        take_snap();
        frame_begin();
        send_byte(8'hC8);
        for (int i = 0; i < 7; i++) send_bit(1'b0);
        sclk = 1'b0; sdata = 1'b0;
        tick(HALF);
        sclk = 1'b1; strobe = 1'b1;
        tick(4 * HALF);
        compare_snap("R9");
        peek(4, v);
        check(v == 16'h3CC3, "R9 digit kept", {16'h0, v}, 32'h3CC3);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule